// File: doc/BRIEF.md
# IrDA SIR receive pulse decoder

This block turns the active-low receive line of an infrared transceiver into the non-return-to-zero serial stream that a 16x-oversampling UART receiver expects. It runs on the system clock. A one-cycle enable, `baudTick`, arrives at sixteen times the baud rate. A bit period is therefore sixteen ticks long. A logical 0 is sent as a short low pulse inside the bit period, and a logical 1 is sent as no pulse at all.

The raw line first passes through a two-flop synchronizer. The decoder then measures how long each low pulse lasts, in system clocks, and compares that width against two programmable counts, a minimum and a maximum. A pulse shorter than the minimum is dropped as noise. A pulse longer than the maximum raises a sticky error flag and is not decoded. A pulse inside the window makes `rxd` low for exactly one bit period, and that period starts eight ticks after the pulse's falling edge. With no pulse, `rxd` stays high. A falling edge that arrives while an output bit is still running starts a new bit period, so back-to-back zeros come out as one unbroken low stretch.

Top module: `irsir_rx_decoder`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `rxd` high and `pulseErr` low, and both stay there after reset until a pulse arrives.
- R2: Call k0 the first clock edge at which `irRxN` is sampled low. Count the edges, from k0+3 onward, that sample `baudTick` high. For a qualified pulse, `rxd` goes low right after the 8th such tick. It returns high right after the 16th tick that follows that one.
- R3: A pulse whose width N (the number of consecutive edges at which `irRxN` is sampled low) satisfies `minWidth` <= N <= `maxWidth` is qualified. Both bounds are inclusive and take effect for any programmed value.
- R4: A pulse with N < `minWidth` is ignored: `rxd` stays high and `pulseErr` stays low.
- R5: A pulse with N > `maxWidth` that ends before the 8th counted tick sets `pulseErr` and produces no low on `rxd`.
- R6: When qualified pulses start every 16 ticks, the output bits join, and `rxd` stays low without a break from the first bit's start to the last bit's end.
- R7: A line still low at the 8th counted tick produces no output bit and sets `pulseErr`.
- R8: Once `pulseErr` is set, it stays set through any later traffic until a reset.
- R9: While `irRxN` stays high, `rxd` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baudTick | input | 1 | One-cycle enable at 16 times the baud rate |
| irRxN | input | 1 | Raw infrared receive line, active low, asynchronous |
| minWidth | input | CNT_W | Shortest accepted pulse, in system clocks |
| maxWidth | input | CNT_W | Longest accepted pulse, in system clocks |
| rxd | output | 1 | Demodulated serial data, idles high |
| pulseErr | output | 1 | Sticky flag for an over-long pulse |

## Verification
The line is driven with pulses of the following kinds:
- a nominal 3/16-bit pulse;
- pulses exactly at the minimum width and one clock under it;
- a pulse one clock over the maximum;
- a pulse held low past the output point, with the maximum raised so that only the latency rule can reject it;
- a train of zeros spaced one bit apart.

The first two widths separate an inclusive lower bound from an exclusive one. The one-over pulse checks both that data is rejected and that the error flag is raised. The zero train shows whether a new edge re-arms the output instead of leaving a one-bit high gap. The bounds are then reprogrammed to show that the limits come from the inputs rather than from constants. Every output edge is checked for its exact cycle against the tick count.

// File: rtl/irsir_pkg.sv
package irsir_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic startLow;   // restart width measurement
    logic countLow;   // width counter enabled
    logic startDly;   // restart latency tick counter
    logic countDly;   // latency counter enabled
    logic loadOut;    // begin an output bit period
    logic setErr;     // raise sticky error
  } irCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic fallEvt;    // synchronized line went low
    logic riseEvt;    // synchronized line went high
    logic inRange;    // measured width within limits
    logic tooLong;    // measured width above maximum
    logic dlyDone;    // latency tick reached this cycle
  } irStat_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HOLD = 2'd2
  } irState_t;

endpackage

// File: rtl/irsir_rx_datapath.sv
module irsir_rx_datapath
  import irsir_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BIT_TICKS   = 16,
  parameter int LAT_TICKS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baudTick,
  input  logic             irRxN,
  input  logic [CNT_W-1:0] minWidth,
  input  logic [CNT_W-1:0] maxWidth,
  input  irCtl_t           ctl,
  output irStat_t          stat,
  output logic             rxd,
  output logic             pulseErr
);

  localparam int DLY_W = (LAT_TICKS > 1) ? $clog2(LAT_TICKS) : 1;
  localparam int OUT_W = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(LAT_TICKS - 1);
  localparam logic [OUT_W-1:0] OUT_LAST = OUT_W'(BIT_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};

  // synchronizer chain, idles high
  logic [SYNC_STAGES-1:0] syncQ;
  logic lineQ, linePrev;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= irRxN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (rst) syncQ <= '1;
        else     syncQ <= {syncQ[SYNC_STAGES-2:0], irRxN};
      end
    end
  endgenerate

  assign lineQ = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) linePrev <= 1'b1;
    else     linePrev <= lineQ;
  end

  // low-width counter, saturating
  logic [CNT_W-1:0] lowCnt;
  always_ff @(posedge clk) begin
    if (rst)                                       lowCnt <= '0;
    else if (ctl.startLow)                         lowCnt <= CNT_W'(1);
    else if (ctl.countLow && !lineQ && lowCnt != CNT_SAT) lowCnt <= lowCnt + 1'b1;
  end

  // latency tick counter
  logic [DLY_W-1:0] dlyCnt;
  always_ff @(posedge clk) begin
    if (rst)                          dlyCnt <= '0;
    else if (ctl.startDly)            dlyCnt <= '0;
    else if (ctl.countDly && baudTick) dlyCnt <= dlyCnt + 1'b1;
  end

  // output bit period
  logic             outActive;
  logic [OUT_W-1:0] outCnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      outActive <= 1'b0;
      outCnt    <= '0;
    end else if (ctl.loadOut) begin
      outActive <= 1'b1;
      outCnt    <= '0;
    end else if (outActive && baudTick) begin
      if (outCnt == OUT_LAST) begin
        outActive <= 1'b0;
        outCnt    <= '0;
      end else begin
        outCnt <= outCnt + 1'b1;
      end
    end
  end

  logic errFlag;
  always_ff @(posedge clk) begin
    if (rst)             errFlag <= 1'b0;
    else if (ctl.setErr) errFlag <= 1'b1;
  end

  assign stat.fallEvt = linePrev & ~lineQ;
  assign stat.riseEvt = ~linePrev & lineQ;
  assign stat.inRange = (lowCnt >= minWidth) && (lowCnt <= maxWidth);
  assign stat.tooLong = (lowCnt > maxWidth);
  assign stat.dlyDone = baudTick && (dlyCnt == DLY_LAST);

  assign rxd      = ~outActive;
  assign pulseErr = errFlag;

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    errFlag |=> errFlag);

  // R5: a rise after an over-long pulse leaves the flag set
  p_long_flags_r5: assert property (@(posedge clk) disable iff (rst)
    (stat.riseEvt && stat.tooLong) |=> errFlag);

  // R4: a short pulse ending never raises the flag
  p_glitch_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (stat.riseEvt && (lowCnt < minWidth) && !errFlag && (minWidth <= maxWidth)) |=> !errFlag);

  // R2: rxd only falls after a load strobe from control
  p_rxd_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rxd) |-> $past(ctl.loadOut));

  // R2: the bit-period count moves only on ticks
  p_out_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (outActive && !baudTick && !ctl.loadOut) |=> (outActive && $stable(outCnt)));

endmodule

// File: rtl/irsir_rx_ctrl.sv
module irsir_rx_ctrl
  import irsir_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  irStat_t stat,
  output irCtl_t  ctl
);

  irState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    ctl          = '0;
    stateNext    = state;
    ctl.countLow = (state == ST_LOW);
    ctl.countDly = (state != ST_IDLE);
    case (state)
      ST_IDLE: begin
        if (stat.fallEvt) begin
          ctl.startLow = 1'b1;
          ctl.startDly = 1'b1;
          stateNext    = ST_LOW;
        end
      end
      ST_LOW: begin
        if (stat.riseEvt) begin
          if (stat.inRange) begin
            if (stat.dlyDone) begin
              ctl.loadOut = 1'b1;
              stateNext   = ST_IDLE;
            end else begin
              stateNext = ST_HOLD;
            end
          end else begin
            ctl.setErr = stat.tooLong;
            stateNext  = ST_IDLE;
          end
        end else if (stat.dlyDone) begin
          // still low at the output point: cannot decode in time
          ctl.setErr = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (stat.fallEvt) begin
          ctl.startLow = 1'b1;
          ctl.startDly = 1'b1;
          stateNext    = ST_LOW;
        end else if (stat.dlyDone) begin
          ctl.loadOut = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R6: a new edge while waiting re-arms measurement
  p_restart_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && stat.fallEvt) |=> (state == ST_LOW));

  // R3: an output bit starts only for an in-range width at the latency tick
  p_load_qualified_r3: assert property (@(posedge clk) disable iff (rst)
    ctl.loadOut |-> (stat.inRange && stat.dlyDone));

  // R7: low at the latency tick ends the attempt
  p_stuck_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOW && !stat.riseEvt && stat.dlyDone) |=> (state == ST_IDLE));

endmodule

// File: rtl/irsir_rx_decoder.sv
module irsir_rx_decoder
  import irsir_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int BIT_TICKS   = 16,
  parameter int LAT_TICKS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             baudTick,
  input  logic             irRxN,
  input  logic [CNT_W-1:0] minWidth,
  input  logic [CNT_W-1:0] maxWidth,
  output logic             rxd,
  output logic             pulseErr
);

  irCtl_t  ctl;
  irStat_t stat;

  irsir_rx_datapath #(
    .CNT_W       (CNT_W),
    .BIT_TICKS   (BIT_TICKS),
    .LAT_TICKS   (LAT_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .baudTick (baudTick),
    .irRxN    (irRxN),
    .minWidth (minWidth),
    .maxWidth (maxWidth),
    .ctl      (ctl),
    .stat     (stat),
    .rxd      (rxd),
    .pulseErr (pulseErr)
  );

  irsir_rx_ctrl u_ctl (
    .clk  (clk),
    .rst  (rst),
    .stat (stat),
    .ctl  (ctl)
  );

endmodule

// File: tb/sim_irsir_rx_decoder.sv
module sim_irsir_rx_decoder;

  localparam int TP = 4;  // clocks per baud tick

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baudTick = 1'b0;
  logic       irRxN = 1'b1;
  logic [7:0] minWidth = 8'd4;
  logic [7:0] maxWidth = 8'd12;
  logic       rxd, pulseErr;

  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;

  typedef struct packed { int lo; int hi; } expItem_t;
  expItem_t expQ[$];

  irsir_rx_decoder u0 (
    .clk(clk), .rst(rst), .baudTick(baudTick), .irRxN(irRxN),
    .minWidth(minWidth), .maxWidth(maxWidth), .rxd(rxd), .pulseErr(pulseErr)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // ticks land on edges whose index is a multiple of TP
  always @(negedge clk) baudTick <= ((cyc + 1) % TP == 0);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: drives a low pulse of width clocks; pushes expected window if qualified
  task automatic sendPulse(input int width);
    int k0, firstTick, lo, hi;
    k0 = cyc + 1;
    firstTick = k0 + 3;
    while (firstTick % TP != 0) firstTick++;
    lo = firstTick + 7 * TP;
    hi = lo + 16 * TP;
    if (width >= int'(minWidth) && width <= int'(maxWidth) && (k0 + width + 2) <= lo) begin
      if (expQ.size() > 0 && expQ[expQ.size()-1].hi == lo) begin
        expItem_t t;
        t = expQ[expQ.size()-1];
        t.hi = hi;
        expQ[expQ.size()-1] = t;
      end else begin
        expItem_t t;
        t.lo = lo;
        t.hi = hi;
        expQ.push_back(t);
      end
    end
    irRxN = 1'b0;
    repeat (width) @(negedge clk);
    irRxN = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    check(rxd == 1'b1, "R1 rxd after reset", rxd, 1);
    check(pulseErr == 1'b0, "R1 pulseErr after reset", pulseErr, 0);
  endtask

  // monitor: compares rxd edges against the expected windows (R2, R6)
  logic rxdPrev = 1'b1;
  always @(negedge clk) begin
    if (!rst) begin
      if (rxdPrev && !rxd) begin
        if (expQ.size() == 0) check(1'b0, "R2 unexpected rxd low", cyc, -1);
        else check(cyc == expQ[0].lo, "R2 rxd fall cycle", cyc, expQ[0].lo);
      end
      if (!rxdPrev && rxd) begin
        if (expQ.size() == 0) check(1'b0, "R2 unexpected rxd rise", cyc, -1);
        else begin
          check(cyc == expQ[0].hi, "R6 rxd rise cycle", cyc, expQ[0].hi);
          void'(expQ.pop_front());
        end
      end
    end
    rxdPrev <= rxd;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog actual=%0d expected=finish", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(1);
    check(rxd == 1'b1, "R1 rxd after reset", rxd, 1);
    check(pulseErr == 1'b0, "R1 pulseErr after reset", pulseErr, 0);

    // R9: no pulse keeps the line high
    idle(80);
    check(rxd == 1'b1, "R9 idle rxd", rxd, 1);

    // R2: nominal 3/16 pulse (12 clocks of 64)
    sendPulse(12);
    idle(150);
    check(pulseErr == 1'b0, "R2 no error on nominal", pulseErr, 0);

    // R3: exactly minimum width
    sendPulse(4);
    idle(150);

    // R4: one below minimum
    sendPulse(3);
    idle(40);
    check(rxd == 1'b1, "R4 short pulse rxd", rxd, 1);
    idle(110);
    check(pulseErr == 1'b0, "R4 short pulse error", pulseErr, 0);

    // R5: one above maximum
    sendPulse(13);
    idle(40);
    check(rxd == 1'b1, "R5 long pulse rxd", rxd, 1);
    check(pulseErr == 1'b1, "R5 long pulse error", pulseErr, 1);
    idle(110);

    // R8: flag survives a good pulse
    sendPulse(6);
    idle(150);
    check(pulseErr == 1'b1, "R8 sticky error", pulseErr, 1);

    doReset();

    // R6: three zeros one bit apart
    for (int i = 0; i < 3; i++) begin
      sendPulse(12);
      idle(16 * TP - 12);
    end
    idle(150);
    check(pulseErr == 1'b0, "R6 no error in train", pulseErr, 0);

    // R3: reprogrammed bounds
    minWidth = 8'd8;
    maxWidth = 8'd20;
    idle(2);
    sendPulse(6);
    idle(150);
    check(pulseErr == 1'b0, "R3 below new minimum", pulseErr, 0);
    sendPulse(20);
    idle(150);
    check(pulseErr == 1'b0, "R3 at new maximum", pulseErr, 0);

    // R7: held low past the output point, maximum not exceeded
    maxWidth = 8'd60;
    idle(2);
    sendPulse(40);
    idle(150);
    check(pulseErr == 1'b1, "R7 stuck low error", pulseErr, 1);
    check(rxd == 1'b1, "R7 stuck low rxd", rxd, 1);

    check(expQ.size() == 0, "R2 all expected bits seen", expQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule